// File: doc/BRIEF.md
# Two-Wire Slave Shift Engine with Clock Stretching

This block is the bit-level half of a two-wire (I2C-style) slave. It watches the open-drain clock and data lines and spots start and stop conditions. Each rising clock edge shifts one data bit into an 8-bit data register, most significant bit first. A 4-bit edge counter advances on both clock edges. After a start, and again when the counter wraps, the block pulls the clock line low and keeps it there until software acts. A slow controller therefore sets the pace of the bus one byte, or one acknowledge bit, at a time.

Software runs the protocol through a small write port. It can load the data register, which also supplies the bit driven onto the data line, and preset the counter. It clears the flags by writing ones and sets the line and interrupt enables. Address matching, read/write direction and acknowledge policy stay in software. A preset of 14 makes the counter wrap after a single bit period, which suits an acknowledge slot. A preset of 0 makes it wrap after a full byte.

Both lines are handled as open drain. For each line the block drives a pull-low enable and takes the resolved level as input. The inputs pass through a synchroniser before any logic uses them.

Top module: `tws_slave_top`

## Requirements
- R1: After reset, all three flags, both interrupts, both pull-low outputs, `data_o` and `count_o` are 0.
- R2: A falling data line while the clock line is high sets `start_flag_o` and clears `count_o` to 0. `start_irq_o` follows the flag while control bit 1 is set.
- R3: After a start, the first falling clock edge makes `scl_low_o` go high. It stays high until software writes a 1 to clear bit 0 (select 2). That write clears the start flag and resets the counter to 0.
- R4: On each rising clock edge the data register shifts left by one and takes the sampled data line into bit 0. After eight bits, `data_o` equals the byte sent MSB first.
- R5: The counter advances on every rising and every falling clock edge. Counting from 0, the 16th edge (the falling edge that ends bit 8) wraps it to 0, sets `ovf_flag_o` and pulls the clock low. After the 15th edge the count is 15 and the clock is not held.
- R6: Writing select 2 with bit 1 set clears the overflow flag and releases the clock line. Writing 0 in that bit leaves the flag and the hold unchanged.
- R7: A write to select 1 loads `count_o` from write bits 3:0. After a preset of 14, one full clock pulse (two edges) causes an overflow with the count back at 0.
- R8: A write to select 0 loads `data_o`. `sda_low_o` is high exactly when control bit 0 (select 3) is set and `data_o[7]` is 0.
- R9: A rising data line while the clock line is high sets `stop_flag_o` and leaves `scl_low_o` low. Writing select 2 with bit 2 set clears the stop flag.
- R10: A start seen in the middle of a byte counts as a repeated start. It sets the start flag again, resets the count to 0 and re-arms the clock hold for the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Resolved level of the clock line |
| sda_i | input | 1 | Resolved level of the data line |
| scl_low_o | output | 1 | Pull the clock line low |
| sda_low_o | output | 1 | Pull the data line low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 data, 1 counter, 2 flag clear, 3 control |
| wr_data | input | 8 | Write value |
| data_o | output | 8 | Data register |
| count_o | output | 4 | Edge counter |
| start_flag_o | output | 1 | Start condition seen |
| ovf_flag_o | output | 1 | Counter wrapped |
| stop_flag_o | output | 1 | Stop condition seen |
| start_irq_o | output | 1 | Start interrupt (flag and enable bit 1) |
| ovf_irq_o | output | 1 | Overflow interrupt (flag and enable bit 2) |

## Verification
A line change becomes visible on the outputs three clock cycles later: two synchroniser stages, then an edge-history flop whose comparison feeds the flag, counter and shift registers. A register write shows on the outputs one cycle later. The bench changes one line at a time on the falling system-clock edge. It then waits four cycles and samples on a falling edge, so each result has settled before it is checked and no later stimulus has touched it. All 256 byte values are sent through a start, a byte, an acknowledge slot and a stop. Separate passes cover a repeated start and the write-0 cases.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_CLR  = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  localparam int CLR_START_BIT = 0;
  localparam int CLR_OVF_BIT   = 1;
  localparam int CLR_STOP_BIT  = 2;

  localparam int CTL_SDA_EN    = 0;
  localparam int CTL_START_IE  = 1;
  localparam int CTL_OVF_IE    = 2;
  localparam int CTL_W         = 3;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              hist;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) hist <= 1'b1;
    else     hist <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~hist;
  assign fall  = ~chain[STAGES-1] & hist;
endmodule

// File: rtl/tws_shift.sv
module tws_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [DATA_W-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (rst)           data_q <= '0;
    else if (wr)       data_q <= wdata;
    else if (shift_en) data_q <= {data_q[DATA_W-2:0], bit_in};
  end

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !wr) |=> data_q == {$past(data_q[DATA_W-2:0]), $past(bit_in)}); // R4
  AST_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr |=> data_q == $past(wdata)); // R8
endmodule

// File: rtl/tws_count.sv
module tws_count #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap_p
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assign wrap_p = tick && !clr && !wr && (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (wr)   cnt_q <= wdata;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr && !wr && cnt_q == CNT_MAX) |=> cnt_q == '0); // R5
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr && !wr && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1); // R5
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt_q == '0); // R10
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr && !clr) |=> cnt_q == $past(wdata)); // R7
endmodule

// File: rtl/tws_slave_top.sv
module tws_slave_top #(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_low_o,
  output logic              sda_low_o,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              start_flag_o,
  output logic              ovf_flag_o,
  output logic              stop_flag_o,
  output logic              start_irq_o,
  output logic              ovf_irq_o
);
  import tws_pkg::*;

  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic start_p, stop_p, wrap_p;
  logic wr_dat, wr_cnt, wr_clr, wr_ctl;
  logic clr_start, clr_ovf, clr_stop;
  logic armed_q, hold_q;
  logic [CTL_W-1:0] ctl_q;
  logic unused_bits;

  tws_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst(rst), .d_in(scl_i),
    .level(scl_lvl), .rise(scl_rise), .fall(scl_fall));

  tws_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst(rst), .d_in(sda_i),
    .level(sda_lvl), .rise(sda_rise), .fall(sda_fall));

  // Bus conditions: data edge while clock is high
  assign start_p = sda_fall & scl_lvl;
  assign stop_p  = sda_rise & scl_lvl;

  assign wr_dat = wr_en && (wr_sel == SEL_DATA);
  assign wr_cnt = wr_en && (wr_sel == SEL_CNT);
  assign wr_clr = wr_en && (wr_sel == SEL_CLR);
  assign wr_ctl = wr_en && (wr_sel == SEL_CTRL);

  assign clr_start = wr_clr & wr_data[CLR_START_BIT];
  assign clr_ovf   = wr_clr & wr_data[CLR_OVF_BIT];
  assign clr_stop  = wr_clr & wr_data[CLR_STOP_BIT];

  assign unused_bits = ^wr_data[DATA_W-1:CTL_W] ^ ^wr_data[CNT_W-1:CTL_W];

  tws_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .wr(wr_dat), .wdata(wr_data),
    .shift_en(scl_rise), .bit_in(sda_lvl), .data_q(data_o));

  tws_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .clr(start_p | clr_start),
    .wr(wr_cnt), .wdata(wr_data[CNT_W-1:0]),
    .tick(scl_rise | scl_fall), .cnt_q(count_o), .wrap_p(wrap_p));

  always_ff @(posedge clk) begin
    if (rst) begin
      start_flag_o <= 1'b0;
      ovf_flag_o   <= 1'b0;
      stop_flag_o  <= 1'b0;
      armed_q      <= 1'b0;
      hold_q       <= 1'b0;
      ctl_q        <= '0;
    end else begin
      if (start_p)        start_flag_o <= 1'b1;
      else if (clr_start) start_flag_o <= 1'b0;

      if (wrap_p)         ovf_flag_o <= 1'b1;
      else if (clr_ovf)   ovf_flag_o <= 1'b0;

      if (stop_p)         stop_flag_o <= 1'b1;
      else if (clr_stop)  stop_flag_o <= 1'b0;

      if (start_p)        armed_q <= 1'b1;
      else if (clr_start || scl_fall) armed_q <= 1'b0;

      if (clr_start)      hold_q <= 1'b0;
      else if (armed_q && scl_fall) hold_q <= 1'b1;

      if (wr_ctl)         ctl_q <= wr_data[CTL_W-1:0];
    end
  end

  assign scl_low_o   = hold_q | ovf_flag_o;
  assign sda_low_o   = ctl_q[CTL_SDA_EN] & ~data_o[DATA_W-1];
  assign start_irq_o = start_flag_o & ctl_q[CTL_START_IE];
  assign ovf_irq_o   = ovf_flag_o & ctl_q[CTL_OVF_IE];

  AST_START_SEEN: assert property (@(posedge clk) disable iff (rst)
    start_p |=> start_flag_o); // R2
  AST_START_HOLD: assert property (@(posedge clk) disable iff (rst)
    (armed_q && scl_fall && !clr_start) |=> scl_low_o); // R3
  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
    (hold_q && !clr_start) |=> scl_low_o); // R3
  AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
    wrap_p |=> (ovf_flag_o && scl_low_o)); // R5
  AST_OVF_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (clr_ovf && !wrap_p && !hold_q && !(armed_q && scl_fall)) |=> !scl_low_o); // R6
  AST_STOP_SEEN: assert property (@(posedge clk) disable iff (rst)
    stop_p |=> stop_flag_o); // R9
endmodule

// File: tb/sim_tws_slave_top.sv
module sim_tws_slave_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_low, sda_low;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] data_o;
  logic [3:0] count_o;
  logic start_f, ovf_f, stop_f, start_irq, ovf_irq;
  logic scl_line, sda_line;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign scl_line = scl_m & ~scl_low;
  assign sda_line = sda_m & ~sda_low;

  tws_slave_top u0 (
    .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
    .scl_low_o(scl_low), .sda_low_o(sda_low),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .data_o(data_o), .count_o(count_o),
    .start_flag_o(start_f), .ovf_flag_o(ovf_f), .stop_flag_o(stop_f),
    .start_irq_o(start_irq), .ovf_irq_o(ovf_irq));

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clock_pulse();
    scl_m = 1'b1; settle();
    scl_m = 1'b0; settle();
  endtask

  task automatic do_start();
    sda_m = 1'b0; settle();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; settle();
    scl_m = 1'b1; settle();
    sda_m = 1'b1; settle();
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    // R1 reset state
    chk("R1 flags", {start_f, ovf_f, stop_f}, 0);
    chk("R1 irqs", {start_irq, ovf_irq}, 0);
    chk("R1 pulls", {scl_low, sda_low}, 0);
    chk("R1 data", data_o, 0);
    chk("R1 count", count_o, 0);

    // enable start/ovf interrupts, data line drive off
    wr(2'd3, 8'b110);

    for (int b = 0; b < 256; b++) begin
      do_start();
      chk("R2 start flag", start_f, 1);
      chk("R2 start irq", start_irq, 1);
      chk("R2 count", count_o, 0);
      chk("R3 no hold before fall", scl_low, 0);
      scl_m = 1'b0; settle();
      chk("R3 hold after fall", scl_low, 1);
      if (b == 0) begin
        wr(2'd2, 8'h00);
        chk("R3 write0 keeps hold", scl_low, 1);
      end
      wr(2'd2, 8'h01);
      chk("R3 release", scl_low, 0);
      chk("R3 count reset", count_o, 0);
      chk("R3 flag cleared", start_f, 0);
      for (int i = 7; i >= 0; i--) begin
        sda_m = b[i]; settle();
        scl_m = 1'b1; settle();
        if (i == 0) begin
          chk("R5 count at 15", count_o, 15);
          chk("R5 no hold at 15", scl_low, 0);
        end
        scl_m = 1'b0; settle();
      end
      chk("R4 byte", data_o, b);
      chk("R5 ovf flag", ovf_f, 1);
      chk("R5 ovf hold", scl_low, 1);
      chk("R5 wrapped", count_o, 0);
      chk("R5 ovf irq", ovf_irq, 1);
      // acknowledge slot: slave pulls data low
      sda_m = 1'b1;
      wr(2'd0, 8'h00);
      wr(2'd3, 8'b111);
      chk("R8 sda pulled", sda_low, 1);
      wr(2'd1, 8'd14);
      chk("R7 preset", count_o, 14);
      if (b == 0) begin
        wr(2'd2, 8'h04);
        chk("R6 write0 keeps ovf", ovf_f, 1);
        chk("R6 write0 keeps hold", scl_low, 1);
      end
      wr(2'd2, 8'h02);
      chk("R6 ovf cleared", ovf_f, 0);
      chk("R6 released", scl_low, 0);
      clock_pulse();
      chk("R7 ack ovf", ovf_f, 1);
      chk("R7 ack hold", scl_low, 1);
      chk("R7 ack count", count_o, 0);
      chk("R4 ack bit shifted", data_o, 0);
      wr(2'd3, 8'b110);
      chk("R8 sda released", sda_low, 0);
      wr(2'd2, 8'h02);
      do_stop();
      chk("R9 stop flag", stop_f, 1);
      chk("R9 no stretch", scl_low, 0);
      wr(2'd2, 8'h04);
      chk("R9 stop cleared", stop_f, 0);
    end

    // R8 with data bit 7 set: no pull
    wr(2'd0, 8'hFF);
    wr(2'd3, 8'b001);
    chk("R8 msb high no pull", sda_low, 0);
    wr(2'd0, 8'h7F);
    chk("R8 msb low pulls", sda_low, 1);
    wr(2'd3, 8'b000);
    chk("R8 disabled no pull", sda_low, 0);

    // R10 repeated start in mid-byte
    do_start();
    scl_m = 1'b0; settle();
    wr(2'd2, 8'h01);
    for (int i = 0; i < 3; i++) begin
      sda_m = 1'b0; settle();
      clock_pulse();
    end
    chk("R10 count mid", count_o, 6);
    chk("R10 start clear mid", start_f, 0);
    sda_m = 1'b1; settle();
    scl_m = 1'b1; settle();
    sda_m = 1'b0; settle();
    chk("R10 restart flag", start_f, 1);
    chk("R10 restart count", count_o, 0);
    scl_m = 1'b0; settle();
    chk("R10 rehold", scl_low, 1);
    wr(2'd2, 8'h01);
    chk("R10 released", scl_low, 0);
    do_stop();
    chk("R9 final stop", stop_f, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule